// File: doc/BRIEF.md
# Whitened CRC Packet Framer

This block turns a payload sitting in a small local byte buffer into one complete radio frame. The frame leaves the block a byte at a time over a valid/ready handshake, so any byte sink can consume it. A frame starts with an unscrambled run of alternating-bit preamble bytes and a fixed four-byte sync word. The length byte, the payload and a CRC-16 follow, and these are XORed with a PN9 whitening stream.

The payload buffer is filled through a simple write port while the block is idle. A one-cycle start strobe carries the payload byte count and a long-preamble flag. The long-preamble flag places a long wake-up run of preamble bytes ahead of the normal preamble. The CRC is accumulated over the plain length byte and payload bytes as they are accepted, and is sent right after them. The block raises a one-cycle completion pulse after the last byte is accepted. A count too large for the whitening span is refused with a one-cycle error pulse.

Top module: `pkt_framer`

## Requirements
- R1: During and directly after reset, outValid, frameDone and frameErr are all 0.
- R2: A normal frame is, in this order: 4 bytes of 0xAA, then the sync bytes 0xE9, 0xCA, 0xE9, 0xCA (not whitened), then the whitened length byte, the whitened payload bytes and the whitened CRC high byte and low byte.
- R3: With startBurst set, 448 extra 0xAA bytes are sent before the 4-byte preamble, and the rest of the frame is unchanged.
- R4: Before whitening, the length byte equals startLen. The payload bytes follow in buffer address order, starting at address 0.
- R5: The CRC-16 uses polynomial 0x8005 and initial value 0xFFFF. It is computed MSB first with no final XOR, over the length byte and then each payload byte, all before whitening.
- R6: Whitening byte k (k = 0 for the length byte) is the low 8 bits of a 9-bit register that starts at all ones and has been stepped 8k times. Each step shifts right and inserts bit0 XOR bit5 at bit 8. The stream begins 0xFF, 0xE1, 0x1D, 0x9A, 0xED, 0x85.
- R7: A start with startLen of 37 or more sends nothing. It raises frameErr for exactly one cycle, in the cycle after the strobe.
- R8: startLen = 0 gives a valid frame holding only the length byte and the two CRC bytes after the sync word.
- R9: A start strobe that arrives while a frame is in progress has no effect.
- R10: While outValid is 1 and outReady is 0, outValid stays 1 and outData stays unchanged in the next cycle.
- R11: frameDone is 1 for exactly one cycle, the cycle after the last CRC byte is accepted. outValid is 0 in that cycle.
- R12: Buffer writes made while a frame is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Payload buffer write strobe |
| wrAddr | input | IDX_W (6) | Payload buffer write address |
| wrData | input | 8 | Payload buffer write data |
| startReq | input | 1 | One-cycle frame launch strobe |
| startBurst | input | 1 | Add the long wake-up preamble |
| startLen | input | 8 | Payload byte count |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Sink accepts the byte |
| outData | output | 8 | Output byte |
| frameDone | output | 1 | One-cycle end-of-frame pulse |
| frameErr | output | 1 | One-cycle oversize rejection pulse |

## Verification
Two pairs of events can coincide in one cycle. The first pair is a sink stall and a field boundary: a stall can land on the last byte of a field, such as the final sync byte or the CRC high byte. A pseudo-random ready pattern lands stalls on every boundary across the full sweep of payload lengths. The held byte is compared on the next cycle, and the full byte stream is compared with a frame the bench builds arithmetically. The second pair is a new start strobe plus a buffer write arriving during a frame. That frame is judged unchanged, no second frame may follow it, and a rerun without refilling the buffer must reproduce the original payload.

// File: rtl/framer_pkg.sv
package framer_pkg;

  localparam logic [7:0]  PRE_PATTERN = 8'hAA;
  localparam logic [31:0] SYNC_WORD   = 32'hE9CAE9CA;  // first byte sent is the top byte
  localparam logic [15:0] CRC_POLY    = 16'h8005;
  localparam logic [15:0] CRC_SEED    = 16'hFFFF;
  localparam logic [8:0]  PN_SEED     = 9'h1FF;

  typedef enum logic [2:0] {
    SEL_PRE,
    SEL_SYNC,
    SEL_LEN,
    SEL_PAY,
    SEL_CRCH,
    SEL_CRCL
  } fieldSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;     // latch length, seed CRC and whitening
    logic      absorb;   // fold current plain byte into CRC
    logic      pnStep;   // advance whitening by one byte
    logic      payStep;  // advance payload read index
    fieldSel_e sel;      // field currently presented
    logic [1:0] syncIdx; // byte within sync word
  } frameStrobes_t;

endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int BURST_BYTES = 448,
  parameter int PRE_BYTES   = 4,
  parameter int MAX_LEN     = 36
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          startBurst,
  input  logic [7:0]    startLen,
  input  logic          outReady,
  output logic          outValid,
  output logic          busy,
  output logic          frameDone,
  output logic          frameErr,
  output frameStrobes_t strobes
);

  localparam int CNT_MAX = (BURST_BYTES > PRE_BYTES) ? BURST_BYTES : PRE_BYTES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] BURST_LAST = CNT_W'(BURST_BYTES - 1);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_BYTES - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST  = CNT_W'(3);

  typedef enum logic [2:0] {
    ST_IDLE, ST_BURST, ST_PRE, ST_SYNC, ST_LEN, ST_PAY, ST_CRCH, ST_CRCL
  } state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       remain;
  logic             idle;
  logic             fire;
  logic             lenOk;

  assign idle     = (state == ST_IDLE);
  assign outValid = !idle;
  assign busy     = !idle;
  assign fire     = outValid && outReady;
  assign lenOk    = (startLen <= 8'(MAX_LEN));

  always_comb begin
    strobes         = '0;
    strobes.syncIdx = cnt[1:0];
    strobes.load    = idle && startReq && lenOk;
    case (state)
      ST_SYNC: strobes.sel = SEL_SYNC;
      ST_LEN:  strobes.sel = SEL_LEN;
      ST_PAY:  strobes.sel = SEL_PAY;
      ST_CRCH: strobes.sel = SEL_CRCH;
      ST_CRCL: strobes.sel = SEL_CRCL;
      default: strobes.sel = SEL_PRE;
    endcase
    strobes.absorb  = fire && (state == ST_LEN || state == ST_PAY);
    strobes.pnStep  = fire && (state == ST_LEN || state == ST_PAY || state == ST_CRCH);
    strobes.payStep = fire && (state == ST_PAY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      remain    <= '0;
      frameDone <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      frameDone <= fire && (state == ST_CRCL);
      frameErr  <= idle && startReq && !lenOk;
      case (state)
        ST_IDLE: if (startReq && lenOk) begin
          remain <= startLen;
          cnt    <= '0;
          state  <= startBurst ? ST_BURST : ST_PRE;
        end
        ST_BURST: if (fire) begin
          if (cnt == BURST_LAST) begin
            cnt   <= '0;
            state <= ST_PRE;
          end else cnt <= cnt + 1'b1;
        end
        ST_PRE: if (fire) begin
          if (cnt == PRE_LAST) begin
            cnt   <= '0;
            state <= ST_SYNC;
          end else cnt <= cnt + 1'b1;
        end
        ST_SYNC: if (fire) begin
          if (cnt == SYNC_LAST) begin
            cnt   <= '0;
            state <= ST_LEN;
          end else cnt <= cnt + 1'b1;
        end
        ST_LEN: if (fire) state <= (remain == 8'd0) ? ST_CRCH : ST_PAY;
        ST_PAY: if (fire) begin
          remain <= remain - 8'd1;
          if (remain == 8'd1) state <= ST_CRCH;
        end
        ST_CRCH: if (fire) state <= ST_CRCL;
        ST_CRCL: if (fire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busy && startReq && !(state == ST_CRCL && fire) |=> busy); // R9

  AST_PAY_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PAY |-> remain != 8'd0); // R4

endmodule

// File: rtl/framer_dpath.sv
module framer_dpath
  import framer_pkg::*;
#(
  parameter int MAX_LEN = 36,
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [7:0]       wrData,
  input  logic             busy,
  input  logic [7:0]       startLen,
  input  frameStrobes_t    strobes,
  output logic [7:0]       outData
);

  logic [7:0]       bufMem [MAX_LEN];
  logic [7:0]       lenByte;
  logic [15:0]      crcReg;
  logic [8:0]       pnReg;
  logic [IDX_W-1:0] payIdx;
  logic [7:0]       payByte;
  logic [7:0]       plainByte;
  logic [7:0]       syncByte;

  function automatic logic [15:0] crcFold(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [8:0] pnAdvance(input logic [8:0] s);
    logic [8:0] r;
    r = s;
    for (int i = 0; i < 8; i++) r = {r[0] ^ r[5], r[8:1]};
    return r;
  endfunction

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rstN) bufMem[g] <= '0;
      else if (wrEn && !busy && wrAddr == IDX_W'(g)) bufMem[g] <= wrData;
    end
  end

  assign payByte   = ({1'b0, payIdx} < (IDX_W+1)'(MAX_LEN)) ? bufMem[payIdx] : 8'h00;
  assign plainByte = (strobes.sel == SEL_LEN) ? lenByte : payByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenByte <= '0;
      crcReg  <= CRC_SEED;
      pnReg   <= PN_SEED;
      payIdx  <= '0;
    end else if (strobes.load) begin
      lenByte <= startLen;
      crcReg  <= CRC_SEED;
      pnReg   <= PN_SEED;
      payIdx  <= '0;
    end else begin
      if (strobes.absorb)  crcReg <= crcFold(crcReg, plainByte);
      if (strobes.pnStep)  pnReg  <= pnAdvance(pnReg);
      if (strobes.payStep) payIdx <= payIdx + 1'b1;
    end
  end

  always_comb begin
    case (strobes.syncIdx)
      2'd0:    syncByte = SYNC_WORD[31:24];
      2'd1:    syncByte = SYNC_WORD[23:16];
      2'd2:    syncByte = SYNC_WORD[15:8];
      default: syncByte = SYNC_WORD[7:0];
    endcase
    case (strobes.sel)
      SEL_SYNC: outData = syncByte;
      SEL_LEN:  outData = lenByte     ^ pnReg[7:0];
      SEL_PAY:  outData = payByte     ^ pnReg[7:0];
      SEL_CRCH: outData = crcReg[15:8] ^ pnReg[7:0];
      SEL_CRCL: outData = crcReg[7:0]  ^ pnReg[7:0];
      default:  outData = PRE_PATTERN;
    endcase
  end

  AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (!rstN)
    busy && strobes.sel == SEL_LEN |-> crcReg == CRC_SEED); // R5

  AST_PN_SEEDED: assert property (@(posedge clk) disable iff (!rstN)
    busy && strobes.sel == SEL_LEN |-> pnReg == PN_SEED); // R6

  AST_PAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.payStep |-> {1'b0, payIdx} < {1'b0, lenByte}); // R4

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import framer_pkg::*;
#(
  parameter int WHITEN_SPAN = 40,
  parameter int BURST_BYTES = 448,
  parameter int PRE_BYTES   = 4,
  localparam int MAX_LEN    = WHITEN_SPAN - 4,
  localparam int IDX_W      = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [7:0]       wrData,
  input  logic             startReq,
  input  logic             startBurst,
  input  logic [7:0]       startLen,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             frameDone,
  output logic             frameErr
);

  frameStrobes_t strobes;
  logic          busy;

  framer_ctrl #(
    .BURST_BYTES(BURST_BYTES),
    .PRE_BYTES  (PRE_BYTES),
    .MAX_LEN    (MAX_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .startBurst(startBurst),
    .startLen  (startLen),
    .outReady  (outReady),
    .outValid  (outValid),
    .busy      (busy),
    .frameDone (frameDone),
    .frameErr  (frameErr),
    .strobes   (strobes)
  );

  framer_dpath #(
    .MAX_LEN(MAX_LEN)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .busy    (busy),
    .startLen(startLen),
    .strobes (strobes),
    .outData (outData)
  );

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData)); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !outValid); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R11

  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> !outValid && !frameDone); // R7

endmodule

// File: tb/tb_pkt_framer.sv
module tb_pkt_framer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL  = 36;
  localparam int BURST = 448;
  localparam int CAPN  = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       startReq = 1'b0;
  logic       startBurst = 1'b0;
  logic [7:0] startLen = '0;
  logic       outValid;
  logic       outReady = 1'b1;
  logic [7:0] outData;
  logic       frameDone;
  logic       frameErr;

  pkt_framer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .startReq(startReq), .startBurst(startBurst), .startLen(startLen),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .frameDone(frameDone), .frameErr(frameErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChk = 0, nBad = 0;
  int cyc = 0, capCnt = 0, doneCnt = 0, errCnt = 0;
  int lastFire = 0, doneCyc = 0, holdBad = 0, stallSeen = 0;
  logic       stallPrev = 1'b0;
  logic [7:0] holdVal = '0;
  logic [7:0] cap [CAPN];
  logic [7:0] payRef [MAXL];
  logic [7:0] expData [CAPN];
  int expCnt = 0;
  bit readyMode = 0;
  logic [15:0] rl = 16'hACE1;

  // monitor: everything sampled at the active edge from settled values
  always @(posedge clk) begin
    if (rstN) begin
      if (stallPrev && (!outValid || outData != holdVal)) holdBad++;
      stallPrev = outValid && !outReady;
      holdVal   = outData;
      if (stallPrev) stallSeen++;
      if (outValid && outReady) begin
        if (capCnt < CAPN) cap[capCnt] = outData;
        capCnt++;
        lastFire = cyc;
      end
      if (frameDone) begin doneCnt++; doneCyc = cyc; end
      if (frameErr) errCnt++;
    end
    cyc++;
  end

  always @(negedge clk) begin
    rl = {rl[14:0], rl[15] ^ rl[13] ^ rl[12] ^ rl[10]};
    outReady = readyMode ? rl[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pnByte(input int k);
    logic [8:0] s = 9'h1FF;
    for (int i = 0; i < 8 * k; i++) s = {s[0] ^ s[5], s[8:1]};
    return s[7:0];
  endfunction

  function automatic logic [15:0] crcAdd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) r = (r[15] ^ d[i]) ? ({r[14:0], 1'b0} ^ 16'h8005) : {r[14:0], 1'b0};
    return r;
  endfunction

  task automatic buildExp(input int len, input bit burst);
    logic [15:0] c = 16'hFFFF;
    logic [7:0] sy [4] = '{8'hE9, 8'hCA, 8'hE9, 8'hCA};
    expCnt = 0;
    for (int i = 0; i < (burst ? BURST : 0) + 4; i++) begin expData[expCnt] = 8'hAA; expCnt++; end
    for (int i = 0; i < 4; i++) begin expData[expCnt] = sy[i]; expCnt++; end
    c = crcAdd(c, 8'(len));
    expData[expCnt] = 8'(len) ^ pnByte(0); expCnt++;
    for (int i = 0; i < len; i++) begin
      c = crcAdd(c, payRef[i]);
      expData[expCnt] = payRef[i] ^ pnByte(i + 1); expCnt++;
    end
    expData[expCnt] = c[15:8] ^ pnByte(len + 1); expCnt++;
    expData[expCnt] = c[7:0]  ^ pnByte(len + 2); expCnt++;
  endtask

  task automatic pulseStart(input int len, input bit burst);
    @(negedge clk);
    startReq = 1'b1; startLen = 8'(len); startBurst = burst;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic runFrame(input int len, input bit burst, input bit fill, input bit interfere, input string req);
    int d0, mis;
    if (fill) begin
      for (int i = 0; i < len; i++) begin
        payRef[i] = 8'(i * 37 + len * 11 + 3);
        @(negedge clk);
        wrEn = 1'b1; wrAddr = 6'(i); wrData = payRef[i];
      end
      @(negedge clk);
      wrEn = 1'b0;
    end
    capCnt = 0;
    d0 = doneCnt;
    pulseStart(len, burst);
    if (interfere) begin
      repeat (6) @(negedge clk);
      startReq = 1'b1; startLen = 8'd5; startBurst = 1'b1;
      wrEn = 1'b1; wrAddr = 6'd0; wrData = ~payRef[0];
      @(negedge clk);
      startReq = 1'b0; wrEn = 1'b0;
    end
    while (doneCnt == d0) @(negedge clk);
    buildExp(len, burst);
    mis = -1;
    for (int i = 0; i < expCnt && i < CAPN; i++)
      if (mis < 0 && cap[i] != expData[i]) mis = i;
    chk(capCnt == expCnt, req, $sformatf("frame byte count len=%0d", len), capCnt, expCnt);
    if (mis >= 0) chk(0, req, $sformatf("frame byte %0d len=%0d", mis, len), cap[mis], expData[mis]);
    else          chk(1, req, "frame bytes", 0, 0);
    chk(doneCyc == lastFire + 1, "R11", "done cycle after last accept", doneCyc - lastFire, 1);
    repeat (4) @(negedge clk);
    chk(!outValid && capCnt == expCnt, interfere ? "R9" : "R11", "no further bytes after done", capCnt, expCnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    chk(frameDone == 1'b0 && frameErr == 1'b0, "R1", "pulses in reset", {frameDone, frameErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !frameDone && !frameErr, "R1", "outputs after reset", {outValid, frameDone, frameErr}, 0);

    // R8: empty payload, length byte whitened with first stream byte 0xFF (R6)
    runFrame(0, 0, 1, 0, "R8");
    chk(cap[8] == 8'hFF, "R6", "zero length byte whitened", cap[8], 8'hFF);
    chk(capCnt == 11, "R8", "zero length frame size", capCnt, 11);

    // R6 anchor: first payload byte whitened with 0xE1, second with 0x1D
    runFrame(5, 0, 1, 0, "R4");
    chk(cap[9] == (payRef[0] ^ 8'hE1), "R6", "payload byte0 whitening", cap[9], payRef[0] ^ 8'hE1);
    chk(cap[10] == (payRef[1] ^ 8'h1D), "R6", "payload byte1 whitening", cap[10], payRef[1] ^ 8'h1D);

    // R2/R5 sweep over every legal length with alternating sink behaviour
    for (int L = 0; L <= MAXL; L++) begin
      readyMode = L[0];
      runFrame(L, 0, 1, 0, "R2");
    end

    // R3 long preamble
    readyMode = 1;
    runFrame(3, 1, 1, 0, "R3");
    chk(capCnt == BURST + 4 + 4 + 3 + 3, "R3", "burst frame size", capCnt, BURST + 14);
    runFrame(MAXL, 1, 1, 0, "R5");

    // R7 oversize rejection
    foreach (payRef[i]) if (i == 0) begin end
    for (int k = 0; k < 3; k++) begin
      int bad = (k == 0) ? 37 : (k == 1) ? 40 : 255;
      e0 = errCnt;
      capCnt = 0;
      pulseStart(bad, k[0]);
      repeat (3) @(negedge clk);
      chk(errCnt == e0 + 1, "R7", $sformatf("error pulse count len=%0d", bad), errCnt - e0, 1);
      chk(capCnt == 0 && !outValid, "R7", "nothing sent on reject", capCnt, 0);
    end

    // R9 + R12: start and buffer write while busy, then rerun on untouched buffer
    readyMode = 1;
    runFrame(20, 0, 1, 1, "R9");
    runFrame(20, 0, 0, 0, "R12");

    // R10 hold under stall
    chk(stallSeen > 0, "R10", "stalls exercised", stallSeen, 1);
    chk(holdBad == 0, "R10", "byte held while stalled", holdBad, 0);

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule